// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches the input side of a bank of general-purpose pins and turns pin activity into interrupt requests. Each pin's level is brought into the clock domain through a short synchronizer chain. It is then compared against a per-pin trigger setting. That setting is made of two bits: a kind bit that chooses edge or level detection, and a sense bit that flips polarity. A detected event sets a sticky pending bit for that pin.

Pending bits are packed 32 to a word and are cleared by writing ones. A matching word of enable bits selects which pending pins drive the single interrupt line toward the host. Software reaches the pending, enable and trigger settings through one simple register bus. Writes are taken on the clock edge and reads are combinational from the address. Pins that a neighbouring block has placed in native mode, or whose input sensing is switched off, never raise events.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every pending bit, every enable bit and every pin's kind and sense bits read 0, and `irq_out` is low.
- R2: With kind 0 and sense 0, a pin's pending bit sets only on a low-to-high change of its synchronized input. A steady level or a falling change leaves it clear.
- R3: With kind 0 and sense 1, the pending bit sets only on a high-to-low change of the synchronized input.
- R4: With kind 1 and sense 0, the pending bit sets while the input is low. If it is cleared while the input is still low, it reads set again afterwards.
- R5: With kind 1 and sense 1, the pending bit sets while the input is high.
- R6: Writing a pending word clears each bit written as 1 and leaves each bit written as 0 unchanged. Writing all ones empties the word.
- R7: A detected event in the same cycle as a write-one clear of that bit leaves the bit set.
- R8: Pending bits latch whatever the enable bits hold. `irq_out` is high exactly when some pin has both its pending and its enable bit set, across all words.
- R9: A pin with `pin_gpio_mode` low or `pin_sense_off` high never sets its pending bit.
- R10: Register map by byte address: pending word w at 0x80+4w, enable word w at 0x90+4w, with pin p at bit p%32 of word p/32. Pin p's trigger word sits at 0x100+8p, with the kind bit at bit 4 and the sense bit at bit 3. Any other address reads 0.
- R11: With the default two synchronizer stages, a pin change driven between clock edges shows in the pending bit after the third rising edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| pin_in | input | 94 | Raw pin levels |
| pin_gpio_mode | input | 94 | 1 = pin used as GPIO, 0 = native function |
| pin_sense_off | input | 94 | 1 = input sensing disabled |
| irq_out | output | 1 | Aggregated interrupt request |

## Verification
The bench times a new edge so that it lands in the very cycle software clears the bit. A design that lets the clear win would drop that interrupt for good. It clears a level-triggered bit while the level is still held: a design that stores a one-shot flag would show the bit empty. Writes of zero are checked as well, because a design that writes the data word instead of masking with it would wipe other pending pins. The pins sitting on both sides of each 32-bit word boundary and the last pin are used, to catch a wrong pin-to-word mapping. Latency is checked cycle by cycle to catch a missing or extra synchronizer stage.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned LANES      = 32;
  localparam int unsigned STAT_BASE  = 32'h080;
  localparam int unsigned EN_BASE    = 32'h090;
  localparam int unsigned CFG_BASE   = 32'h100;
  localparam int unsigned CFG_STRIDE = 8;
  localparam int unsigned KIND_BIT   = 4;
  localparam int unsigned SENSE_BIT  = 3;

  function automatic logic [31:0] stat_addr(int unsigned word);
    return 32'(STAT_BASE + 4 * word);
  endfunction

  function automatic logic [31:0] en_addr(int unsigned word);
    return 32'(EN_BASE + 4 * word);
  endfunction

  function automatic logic [31:0] cfg_addr(int unsigned pin);
    return 32'(CFG_BASE + CFG_STRIDE * pin);
  endfunction

  // kind: 0 edge, 1 level; sense flips polarity
  function automatic logic trig_hit(logic kind, logic sense, logic cur, logic prev);
    if (kind) return sense ? cur : ~cur;
    return sense ? (prev & ~cur) : (cur & ~prev);
  endfunction
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned NPIN        = 94,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] cur,
  output logic [NPIN-1:0] prev
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [NPIN-1:0] stg [SYNC_STAGES];
  logic [NPIN-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) stg[s] <= '0;
      prev_q <= '0;
    end else begin
      stg[0] <= pin_in;
      for (int s = 1; s < SYNC_STAGES; s++) stg[s] <= stg[s-1];
      prev_q <= stg[LAST];
    end
  end

  assign cur  = stg[LAST];
  assign prev = prev_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPIN = 94
) (
  input  logic [NPIN-1:0] cur,
  input  logic [NPIN-1:0] prev,
  input  logic [NPIN-1:0] trig_kind,
  input  logic [NPIN-1:0] trig_sense,
  input  logic [NPIN-1:0] pin_gpio_mode,
  input  logic [NPIN-1:0] pin_sense_off,
  output logic [NPIN-1:0] event_vec
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    assign event_vec[i] = pin_gpio_mode[i] & ~pin_sense_off[i]
                        & trig_hit(trig_kind[i], trig_sense[i], cur[i], prev[i]);
  end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPIN   = 94,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [LANES-1:0]  bus_wdata,
  output logic [LANES-1:0]  bus_rdata,
  input  logic [NPIN-1:0]   event_vec,
  output logic [NPIN-1:0]   status_q,
  output logic [NPIN-1:0]   enable_q,
  output logic [NPIN-1:0]   trig_kind,
  output logic [NPIN-1:0]   trig_sense
);
  logic [31:0]     addr32;
  logic [NPIN-1:0] clr_vec;
  logic [NPIN-1:0] en_hit;
  logic [NPIN-1:0] cfg_hit;

  assign addr32 = 32'(bus_addr);

  for (genvar i = 0; i < NPIN; i++) begin : g_dec
    localparam int unsigned W = i / LANES;
    localparam int unsigned L = i % LANES;
    assign clr_vec[i] = bus_wr && (addr32 == stat_addr(W)) && bus_wdata[L];
    assign en_hit[i]  = bus_wr && (addr32 == en_addr(W));
    assign cfg_hit[i] = bus_wr && (addr32 == cfg_addr(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q   <= '0;
      enable_q   <= '0;
      trig_kind  <= '0;
      trig_sense <= '0;
    end else begin
      // a fresh event outranks a clear of the same bit
      status_q <= (status_q & ~clr_vec) | event_vec;
      for (int i = 0; i < NPIN; i++) begin
        if (en_hit[i]) enable_q[i] <= bus_wdata[i % LANES];
        if (cfg_hit[i]) begin
          trig_kind[i]  <= bus_wdata[KIND_BIT];
          trig_sense[i] <= bus_wdata[SENSE_BIT];
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NPIN; i++) begin
      if (addr32 == stat_addr(i / LANES)) bus_rdata[i % LANES] = status_q[i];
      if (addr32 == en_addr(i / LANES))   bus_rdata[i % LANES] = enable_q[i];
      if (addr32 == cfg_addr(i)) begin
        bus_rdata[KIND_BIT]  = trig_kind[i];
        bus_rdata[SENSE_BIT] = trig_sense[i];
      end
    end
  end

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(clr_vec & ~event_vec)) == '0)); // R6
  AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(event_vec)) == $past(event_vec))); // R7
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(event_vec)) == '0)); // R2
  AST_ENABLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_hit == '0) |=> $stable(enable_q)); // R8
  AST_TRIG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_hit == '0) |=> ($stable(trig_kind) && $stable(trig_sense))); // R10
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPIN        = 94,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPIN-1:0]   pin_in,
  input  logic [NPIN-1:0]   pin_gpio_mode,
  input  logic [NPIN-1:0]   pin_sense_off,
  output logic              irq_out
);
  logic [NPIN-1:0] cur, prev, event_vec;
  logic [NPIN-1:0] status_q, enable_q, trig_kind, trig_sense;

  gpio_irq_sync #(.NPIN(NPIN), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cur(cur), .prev(prev));

  gpio_irq_detect #(.NPIN(NPIN)) u_detect (
    .cur(cur), .prev(prev), .trig_kind(trig_kind), .trig_sense(trig_sense),
    .pin_gpio_mode(pin_gpio_mode), .pin_sense_off(pin_sense_off),
    .event_vec(event_vec));

  gpio_irq_regs #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .event_vec(event_vec),
    .status_q(status_q), .enable_q(enable_q),
    .trig_kind(trig_kind), .trig_sense(trig_sense));

  assign irq_out = |(status_q & enable_q);

  AST_GATED_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q)
               & ~$past(pin_gpio_mode & ~pin_sense_off)) == '0)); // R9
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_q == '0) |-> !irq_out); // R8
endmodule

// File: tb/gpio_irq_ctrl_bench.sv
module gpio_irq_ctrl_bench;
  localparam int NPIN = 94;
  localparam int NVEC = 10;
  // {pin[6:0], kind, sense, start level, final level, expected pending}
  localparam logic [11:0] VEC [NVEC] = '{
    {7'd0,  1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
    {7'd0,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {7'd31, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
    {7'd31, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    {7'd32, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    {7'd32, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    {7'd63, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    {7'd63, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {7'd64, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    {7'd93, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NPIN-1:0] pins = '0;
  logic [NPIN-1:0] gmode = '1;
  logic [NPIN-1:0] soff = '0;
  logic irq_out;
  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] rd;

  always #5 clk = ~clk;

  gpio_irq_ctrl u_gpio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pins),
    .pin_gpio_mode(gmode), .pin_sense_off(soff), .irq_out(irq_out));

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 12'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rdreg(int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 12'(a);
    #1 d = bus_rdata;
  endtask

  function automatic int stat_of(int p); return 'h80 + 4 * (p / 32); endfunction

  task automatic pend(int p, output logic b);
    logic [31:0] v;
    rdreg(stat_of(p), v);
    b = v[p % 32];
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rdreg('h80, rd); chk("R1 pend0", rd, 0);
    rdreg('h88, rd); chk("R1 pend2", rd, 0);
    rdreg('h94, rd); chk("R1 en1", rd, 0);
    rdreg('h100 + 8 * 5, rd); chk("R1 trig5", rd, 0);
    chk("R1 irq", 32'(irq_out), 0);
    // R10 map
    wr('h100 + 8 * 70, 32'hFFFF_FFFF);
    rdreg('h100 + 8 * 70, rd); chk("R10 trig70", rd, 32'h18);
    wr('h100 + 8 * 70, 32'h0);
    rdreg('h8C, rd); chk("R10 unmapped", rd, 0);

    // R11 latency: pin 10 rising
    @(negedge clk); pins[10] = 1'b1; bus_addr = 12'h80;
    @(negedge clk); #1 chk("R11 edge1", 32'(bus_rdata[10]), 0);
    @(negedge clk); #1 chk("R11 edge2", 32'(bus_rdata[10]), 0);
    @(negedge clk); #1 chk("R11 edge3", 32'(bus_rdata[10]), 1);

    // R6 write-one-to-clear
    pins[11] = 1'b1; repeat (5) @(negedge clk);
    wr('h80, 32'h0);
    rdreg('h80, rd); chk("R6 zero write", rd & 32'hC00, 32'hC00);
    wr('h80, 32'h800);
    rdreg('h80, rd); chk("R6 single clear", rd & 32'hC00, 32'h400);

    // R8 aggregation and enable gating
    chk("R8 latched no irq", 32'(irq_out), 0);
    wr('h90, 32'h400);
    #1 chk("R8 irq on", 32'(irq_out), 1);
    wr('h80, 32'hFFFF_FFFF);
    rdreg('h80, rd); chk("R6 all ones", rd, 0);
    chk("R8 irq off", 32'(irq_out), 0);
    wr('h90, 32'h0);
    wr('h98, 32'h2000_0000);
    pins[93] = 1'b1; repeat (5) @(negedge clk);
    chk("R8 irq last pin", 32'(irq_out), 1);
    wr('h98, 32'h0); wr('h88, 32'hFFFF_FFFF); pins[93] = 1'b0;

    // R7 edge in the clearing cycle: pin 12 already pending
    pins[12] = 1'b1; repeat (5) @(negedge clk);
    pins[12] = 1'b0; repeat (4) @(negedge clk);
    pins[12] = 1'b1;
    @(negedge clk);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 12'h80; bus_wdata = 32'h1000;
    @(negedge clk); bus_wr = 1'b0;
    pend(12, b); chk("R7 kept", 32'(b), 1);

    // R4 level low held through clear
    wr('h100 + 8 * 40, 32'h10);
    repeat (4) @(negedge clk);
    wr('h84, 32'h100);
    pend(40, b); chk("R4 reasserts", 32'(b), 1);
    pins[40] = 1'b1; repeat (4) @(negedge clk);
    wr('h84, 32'h100);
    pend(40, b); chk("R4 released", 32'(b), 0);

    // R9 suppression
    gmode[20] = 1'b0; pins[20] = 1'b1; repeat (5) @(negedge clk);
    pend(20, b); chk("R9 native", 32'(b), 0);
    gmode[20] = 1'b1;
    soff[21] = 1'b1; pins[21] = 1'b1; repeat (5) @(negedge clk);
    pend(21, b); chk("R9 sense off", 32'(b), 0);
    soff[21] = 1'b0;

    // table walk: R2 R3 R4 R5
    for (int k = 0; k < NVEC; k++) begin
      int p;
      logic kd, sn, st, fn, ex;
      string tag;
      {p, kd, sn, st, fn, ex} = {25'd0, VEC[k]};
      tag = kd ? (sn ? "R5 level high" : "R4 level low")
               : (sn ? "R3 falling" : "R2 rising");
      wr('h100 + 8 * p, {27'd0, kd, sn, 3'd0});
      pins[p] = st;
      repeat (6) @(negedge clk);
      wr(stat_of(p), 32'hFFFF_FFFF);
      repeat (2) @(negedge clk);
      pins[p] = fn;
      repeat (6) @(negedge clk);
      pend(p, b);
      chk(tag, 32'(b), 32'(ex));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule